// File: doc/BRIEF.md
# Register Preload and Observe Controller

This block is the test-access controller for an array of two-register macrocells. It has two test modes. In preload mode, a strobe forces known levels into a chosen group of registers. Those levels come straight from the data pins and ignore each register's polarity and D/T type. In observe mode, each macrocell's buried second register is steered onto its output pin while that pin's output enable is active. A security bit blocks both modes, and when it is set the array runs normally.

The array is split into even and odd macrocells and into two register banks. A single strobe loads exactly one half of one bank, which is NUM_MC/2 registers (12 by default). The registered mode requests are resolved with preload taking precedence over observe. The load strobes themselves are combinational in the strobe, so the write happens on the strobe pulse and does not wait for a clock edge.

Top module: `regbank_test_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released until a mode is requested, every load strobe and every observe select is 0.
- R2: The mode requests preload_en_i and observe_en_i are sampled on the rising clock edge. A request takes effect only after that edge.
- R3: In preload mode, with strobe_i high and secure_i low, exactly NUM_MC/2 load strobes are high. The bank is chosen by q_sel_i (0 selects q1_ld_o, 1 selects q2_ld_o). The half is chosen by half_sel_i (0 selects even macrocells, 1 selects odd macrocells, where macrocell m is odd when bit 0 of m is 1).
- R4: The load strobes follow the level of strobe_i combinationally within a clock period. No clock edge is needed between strobe rise, load and strobe fall.
- R5: ld_data_o[m] always equals pin_data_i[m/2] (integer division), whatever the mode, bank or half selection.
- R6: In observe mode, with secure_i low, obs_sel_o[m] equals oe_i[m] for every macrocell m.
- R7: While secure_i is high, all load strobes and observe selects are 0. This takes effect combinationally, in the same cycle.
- R8: When both mode requests are high, preload mode is entered and every obs_sel_o bit is 0.
- R9: Outside preload mode, strobe_i has no effect: all load strobes stay 0.

Each obs_sel_o bit is 1 to route Q2 to the pin and 0 for normal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for mode sampling |
| rst_ni | input | 1 | Active-low asynchronous reset |
| preload_en_i | input | 1 | Preload mode request |
| observe_en_i | input | 1 | Observe mode request |
| strobe_i | input | 1 | Preload strobe, active high |
| q_sel_i | input | 1 | Bank select: 0 = first register, 1 = second register |
| half_sel_i | input | 1 | Half select: 0 = even macrocells, 1 = odd macrocells |
| pin_data_i | input | NUM_MC/2 | Levels from the odd data pins |
| oe_i | input | NUM_MC | Per-macrocell output enables |
| secure_i | input | 1 | Security bit; blocks both test modes |
| q1_ld_o | output | NUM_MC | Load strobes for first registers |
| q2_ld_o | output | NUM_MC | Load strobes for second registers |
| ld_data_o | output | NUM_MC | Load data for each macrocell |
| obs_sel_o | output | NUM_MC | Per-pin observe multiplexer select |

## Verification
A wrong mode register shows up as strobes or observe selects that appear one cycle early, one cycle late, or in the wrong mode. This is visible on the first strobe or output enable after the faulty edge. A decode fault shows up on the very next strobe, as a load count other than NUM_MC/2 or as strobes in the wrong bank or half. A data mapping fault corrupts ld_data_o at once, in every mode. A security gating fault leaves strobes or selects high while secure_i is set, which is observable in the same cycle.

// File: rtl/regbank_test_pkg.sv
package regbank_test_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_PRELOAD = 2'd1,
    MODE_OBSERVE = 2'd2
  } tm_mode_e;
endpackage

// File: rtl/regbank_mode_reg.sv
module regbank_mode_reg
  import regbank_test_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     preload_en_i,
  input  logic     observe_en_i,
  output tm_mode_e mode_o
);
  tm_mode_e mode_d, mode_q;

  always_comb begin
    mode_d = MODE_IDLE;
    if (preload_en_i)      mode_d = MODE_PRELOAD;  // preload wins
    else if (observe_en_i) mode_d = MODE_OBSERVE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_IDLE;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  a_r8_preload_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_en_i |=> mode_q == MODE_PRELOAD);
  a_r2_idle_when_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preload_en_i && !observe_en_i) |=> mode_q == MODE_IDLE);
endmodule

// File: rtl/regbank_load_decode.sv
module regbank_load_decode
  import regbank_test_pkg::*;
#(
  parameter int NUM_MC = 24,
  localparam int HALF = NUM_MC / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tm_mode_e          mode_i,
  input  logic              strobe_i,
  input  logic              q_sel_i,
  input  logic              half_sel_i,
  input  logic              secure_i,
  input  logic [HALF-1:0]   pin_data_i,
  output logic [NUM_MC-1:0] q1_ld_o,
  output logic [NUM_MC-1:0] q2_ld_o,
  output logic [NUM_MC-1:0] ld_data_o
);
  logic fire;
  assign fire = strobe_i && (mode_i == MODE_PRELOAD) && !secure_i;

  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    localparam logic ODD = (m % 2) == 1;
    logic hit;
    assign hit          = fire && (half_sel_i == ODD);
    assign q1_ld_o[m]   = hit && !q_sel_i;
    assign q2_ld_o[m]   = hit && q_sel_i;
    assign ld_data_o[m] = pin_data_i[m/2];  // i-th pin -> i-th cell of half
  end

  a_r3_exact_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{q1_ld_o, q2_ld_o}) |-> $countones({q1_ld_o, q2_ld_o}) == HALF);
  a_r3_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|q1_ld_o) && (|q2_ld_o)));
  a_r4_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{q1_ld_o, q2_ld_o}) |-> strobe_i);
  a_r9_mode_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_PRELOAD) |-> !(|{q1_ld_o, q2_ld_o}));
endmodule

// File: rtl/regbank_observe_sel.sv
module regbank_observe_sel
  import regbank_test_pkg::*;
#(
  parameter int NUM_MC = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tm_mode_e          mode_i,
  input  logic              secure_i,
  input  logic [NUM_MC-1:0] oe_i,
  output logic [NUM_MC-1:0] obs_sel_o
);
  logic obs_on;
  assign obs_on = (mode_i == MODE_OBSERVE) && !secure_i;

  for (genvar m = 0; m < NUM_MC; m++) begin : g_pin
    assign obs_sel_o[m] = obs_on && oe_i[m];
  end

  a_r6_only_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obs_sel_o & ~oe_i) == '0);
  a_r8_not_in_preload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PRELOAD) |-> obs_sel_o == '0);
endmodule

// File: rtl/regbank_test_ctrl.sv
module regbank_test_ctrl
  import regbank_test_pkg::*;
#(
  parameter int NUM_MC = 24,
  localparam int HALF = NUM_MC / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              preload_en_i,
  input  logic              observe_en_i,
  input  logic              strobe_i,
  input  logic              q_sel_i,
  input  logic              half_sel_i,
  input  logic [HALF-1:0]   pin_data_i,
  input  logic [NUM_MC-1:0] oe_i,
  input  logic              secure_i,
  output logic [NUM_MC-1:0] q1_ld_o,
  output logic [NUM_MC-1:0] q2_ld_o,
  output logic [NUM_MC-1:0] ld_data_o,
  output logic [NUM_MC-1:0] obs_sel_o
);
  tm_mode_e mode;

  regbank_mode_reg u_mode (
    .clk_i, .rst_ni, .preload_en_i, .observe_en_i, .mode_o(mode)
  );

  regbank_load_decode #(.NUM_MC(NUM_MC)) u_load (
    .clk_i, .rst_ni, .mode_i(mode), .strobe_i, .q_sel_i, .half_sel_i,
    .secure_i, .pin_data_i, .q1_ld_o, .q2_ld_o, .ld_data_o
  );

  regbank_observe_sel #(.NUM_MC(NUM_MC)) u_obs (
    .clk_i, .rst_ni, .mode_i(mode), .secure_i, .oe_i, .obs_sel_o
  );

  a_r7_secure_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    secure_i |-> (q1_ld_o == '0 && q2_ld_o == '0 && obs_sel_o == '0));
  a_r8_modes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|obs_sel_o) && (|{q1_ld_o, q2_ld_o})));
endmodule

// File: tb/regbank_test_ctrl_bench.sv
module regbank_test_ctrl_bench;
  localparam int N = 24;
  localparam int H = N / 2;

  logic clk = 0, rst_n = 0;
  logic pre_en = 0, obs_en = 0, strobe = 0, q_sel = 0, half_sel = 0, secure = 0;
  logic [H-1:0] pdata = '0;
  logic [N-1:0] oe = '0;
  logic [N-1:0] q1_ld, q2_ld, ld_data, obs_sel;

  int checks = 0, fails = 0;
  int m_mode = 0;  // 0 idle, 1 preload, 2 observe
  bit done = 0;

  always #5 clk = ~clk;

  regbank_test_ctrl u_regbank_test_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .preload_en_i(pre_en), .observe_en_i(obs_en),
    .strobe_i(strobe), .q_sel_i(q_sel), .half_sel_i(half_sel), .pin_data_i(pdata),
    .oe_i(oe), .secure_i(secure), .q1_ld_o(q1_ld), .q2_ld_o(q2_ld),
    .ld_data_o(ld_data), .obs_sel_o(obs_sel)
  );

  function automatic logic [N-1:0] exp_ld(input int md, input logic bank);
    logic [N-1:0] r = '0;
    if (md == 1 && strobe && !secure && q_sel == bank)
      for (int m = 0; m < N; m++) r[m] = ((m % 2) == int'(half_sel));
    return r;
  endfunction

  function automatic logic [N-1:0] exp_data();
    logic [N-1:0] r;
    for (int m = 0; m < N; m++) r[m] = pdata[m/2];
    return r;
  endfunction

  function automatic logic [N-1:0] exp_obs(input int md);
    return (md == 2 && !secure) ? oe : '0;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " R3 q1"}, q1_ld, exp_ld(m_mode, 1'b0));
    chk({tag, " R3 q2"}, q2_ld, exp_ld(m_mode, 1'b1));
    chk({tag, " R5 data"}, ld_data, exp_data());
    chk({tag, " R6 obs"}, obs_sel, exp_obs(m_mode));
  endtask

  // apply mode request, clock it in, update model
  task automatic set_mode(input logic p, input logic o);
    @(negedge clk);
    pre_en = p; obs_en = o;
    @(posedge clk);
    m_mode = p ? 1 : (o ? 2 : 0);
    #2;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset with requests and strobe active
    pre_en = 1; obs_en = 1; strobe = 1; oe = '1; pdata = 12'hA5C;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset q1", q1_ld, '0);
    chk("R1 reset q2", q2_ld, '0);
    chk("R1 reset obs", obs_sel, '0);
    @(negedge clk);
    pre_en = 0; obs_en = 0; strobe = 0;
    rst_n = 1;
    @(posedge clk); #2;
    chk("R1 idle after reset", obs_sel | q1_ld | q2_ld, '0);

    // R2: request not effective before the edge
    @(negedge clk);
    pre_en = 1; strobe = 1; q_sel = 0; half_sel = 0; #1;
    chk("R2 before edge", q1_ld | q2_ld, '0);
    @(posedge clk); m_mode = 1; #2;
    chk("R2 after edge q1", q1_ld, exp_ld(1, 1'b0));

    // R4: strobe pulse within one period
    @(negedge clk);
    strobe = 0; q_sel = 1; half_sel = 1; #1;
    chk("R4 strobe low", q2_ld, '0);
    strobe = 1; #1;
    chk("R4 strobe high", q2_ld, {H{2'b10}});
    strobe = 0; #1;
    chk("R4 strobe fell", q2_ld, '0);

    // R7: security mid-cycle
    strobe = 1; secure = 1; #1;
    chk("R7 secure preload", q1_ld | q2_ld, '0);
    secure = 0;
    set_mode(1'b0, 1'b1);
    oe = 24'hF0F00F;
    secure = 1; #1;
    chk("R7 secure observe", obs_sel, '0);
    secure = 0; #1;
    chk("R6 observe", obs_sel, 24'hF0F00F);

    // R9: strobe ignored in observe and idle
    strobe = 1; #1;
    chk("R9 strobe in observe", q1_ld | q2_ld, '0);
    set_mode(1'b0, 1'b0);
    chk("R9 strobe in idle", q1_ld | q2_ld, '0);

    // R8: both requests
    set_mode(1'b1, 1'b1);
    chk("R8 obs suppressed", obs_sel, '0);
    q_sel = 0; half_sel = 1; #1;
    chk("R8 preload active", q1_ld, {H{2'b10}});

    // random mix
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pre_en   = ($urandom % 3) == 0;
      obs_en   = ($urandom % 2) == 0;
      strobe   = $urandom % 2;
      q_sel    = $urandom % 2;
      half_sel = $urandom % 2;
      secure   = ($urandom % 8) == 0;
      pdata    = H'($urandom);
      oe       = N'($urandom);
      @(posedge clk);
      m_mode = pre_en ? 1 : (obs_en ? 2 : 0);
      #2;
      chk_all("rand");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule